// File: doc/BRIEF.md
# B-tree Index Walker

This block finds which entry of a segment table owns a virtual address. Software keeps a B-tree in memory: the keys are virtual addresses, and the leaves pair each key with a segment table index. When the segment lookup upstream misses, it hands the address to this walker. The walker starts at a root pointer held in a register that software writes. At each node it finds the last key that does not exceed the address, and it descends until it reaches a leaf. It then returns the index found there, or an error code.

Each node fills one 64-byte line. Nodes are looked up in a small direct-mapped node cache first. A miss issues one line read on a simple memory read port and installs the returned line in the cache. The hardware never writes the tree. After software edits the tree, a flush input drops every cached node. A walk that would need more nodes than the depth cap stops and reports an error without fetching any further node.

Top module: `segidx_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_req_valid` are 0. A request is taken when `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 until the cycle after the response.
- R2: Node line layout, used by both hardware and software. Bit 0 is the leaf flag. Bits 3:1 are the key count n (0..7). Key i (i<n) occupies bits 32+32i..63+32i. Slot j occupies bits 256+32j..287+32j. On an internal node, the walker follows slot c, where c is the number of keys among the first n that are less than or equal to the address (unsigned). So a node with no keys, or an address below key 0, follows slot 0.
- R3: On a leaf with c>=1, the response carries the low 11 bits of slot c-1, with `resp_err` = 0. A key equal to the address selects that key.
- R4: On a leaf with c=0, the response carries `resp_err` = 2 (no owner).
- R5: The walk may visit at most 8 nodes. When the 8th node is internal, the response carries `resp_err` = 1 and no further node is read. A path whose leaf is the 8th node completes normally.
- R6: When a node is in the node cache, no memory read is issued for it. `mem_req_valid` is a one-cycle pulse and is 0 while the walker is idle.
- R7: A line returned by memory is installed in the node cache, so repeating a walk over the same nodes issues no memory reads.
- R8: A `flush` pulse while idle invalidates every cached node, and the next walk reads all of its nodes from memory.
- R9: A `flush` during a walk does not change that walk's result. No line that this walk fetches afterwards is installed.
- R10: `root_wr_en` loads `root_wr_ptr` into the root register. A walk uses the root value held when it was accepted; a write during a walk affects only later walks.
- R11: Each accepted request gives exactly one single-cycle `resp_valid`. With both nodes of a two-level walk cached, `resp_valid` rises 4 cycles after the accepting edge.
- R12: Node pointers are byte addresses. The low 6 bits are ignored: `mem_req_addr` always has its low 6 bits at 0, and the node cache is indexed and tagged by bits 31:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate the whole node cache |
| root_wr_en | input | 1 | Load the root pointer register |
| root_wr_ptr | input | 32 | New root node pointer |
| req_valid | input | 1 | Start a walk |
| req_vaddr | input | 32 | Virtual address to locate |
| req_ready | output | 1 | Walker idle and able to take a request |
| resp_valid | output | 1 | Result valid, one cycle |
| resp_index | output | 11 | Segment table index |
| resp_err | output | 2 | 0 ok, 1 depth exceeded, 2 no owning key |
| mem_req_valid | output | 1 | Line read request, one cycle |
| mem_req_addr | output | 32 | Line-aligned byte address of the node |
| mem_rsp_valid | input | 1 | Returned line valid |
| mem_rsp_line | input | 512 | Returned node line |

## Verification
The hardest cases to reach are those that depend on timing inside a walk. One is a flush that lands while a node read is still outstanding. The other is a root write made in the middle of a walk. For both, the bench waits until it sees `mem_req_valid` and then injects the flush or the root write in the same cycle, so the event falls while the walker is waiting on memory. The bench then repeats the walk and counts memory reads to show that nothing was installed. The depth cap is reached with a chain of eight keyless internal nodes. A second chain, seven internal nodes ending in a leaf, shows the last legal level.

// File: rtl/segw_pkg.sv
package segw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FETCH   = 3'd1,
    ST_WAIT    = 3'd2,
    ST_COMPARE = 3'd3,
    ST_DONE    = 3'd4
  } walk_state_t;

  typedef enum logic [1:0] {
    WERR_NONE    = 2'd0,
    WERR_DEPTH   = 2'd1,
    WERR_NOMATCH = 2'd2
  } walk_err_t;

endpackage

// File: rtl/segw_key_select.sv
// Combinational node decode: count of keys <= address picks the slot (R2, R3, R4).
module segw_key_select #(
  parameter int KEY_W    = 32,
  parameter int PTR_W    = 32,
  parameter int MAX_KEYS = 7,
  parameter int LINE_W   = 512
) (
  input  logic [LINE_W-1:0] node_line,
  input  logic [KEY_W-1:0]  vaddr,
  output logic              is_leaf,
  output logic              no_match,
  output logic [PTR_W-1:0]  sel_slot
);
  localparam int CNT_W     = $clog2(MAX_KEYS + 1);
  localparam int SLOT_BASE = KEY_W * (MAX_KEYS + 1);
  localparam int NSLOT     = MAX_KEYS + 1;

  logic [CNT_W-1:0]    key_cnt;
  logic [MAX_KEYS-1:0] key_le;
  logic [PTR_W-1:0]    slot_arr [NSLOT];
  logic [CNT_W-1:0]    n_le;
  logic [CNT_W-1:0]    slot_pick;
  logic                unused_hdr;

  assign is_leaf    = node_line[0];
  assign key_cnt    = node_line[CNT_W:1];
  assign unused_hdr = ^node_line[KEY_W-1:CNT_W+1];

  for (genvar gi = 0; gi < MAX_KEYS; gi++) begin : g_cmp
    logic [KEY_W-1:0] key_i;
    assign key_i      = node_line[KEY_W*(gi+1) +: KEY_W];
    assign key_le[gi] = (CNT_W'(gi) < key_cnt) && (key_i <= vaddr);
  end

  for (genvar gj = 0; gj < NSLOT; gj++) begin : g_slot
    assign slot_arr[gj] = node_line[SLOT_BASE + PTR_W*gj +: PTR_W];
  end

  always_comb begin
    n_le = '0;
    for (int i = 0; i < MAX_KEYS; i++) begin
      n_le = n_le + CNT_W'(key_le[i]);
    end
    no_match  = is_leaf && (n_le == '0);
    slot_pick = is_leaf ? (n_le - CNT_W'(1)) : n_le;
    sel_slot  = slot_arr[slot_pick];
  end

endmodule

// File: rtl/segw_node_cache.sv
// Direct-mapped node cache with whole-array invalidate (R6, R7, R8, R12).
module segw_node_cache #(
  parameter int PTR_W    = 32,
  parameter int LINE_W   = 512,
  parameter int ENTRIES  = 8,
  parameter int LINE_OFS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PTR_W-1:0]  lk_ptr,
  output logic              hit,
  output logic [LINE_W-1:0] hit_line,
  input  logic              fill_en,
  input  logic [PTR_W-1:0]  fill_ptr,
  input  logic [LINE_W-1:0] fill_line
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PTR_W - LINE_OFS - IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [LINE_W-1:0]  dat_q [ENTRIES];
  logic [IDX_W-1:0]   lk_idx, fill_idx;
  logic [TAG_W-1:0]   lk_tag, fill_tag;
  logic               unused_ofs;

  assign lk_idx     = lk_ptr[LINE_OFS +: IDX_W];
  assign lk_tag     = lk_ptr[PTR_W-1 -: TAG_W];
  assign fill_idx   = fill_ptr[LINE_OFS +: IDX_W];
  assign fill_tag   = fill_ptr[PTR_W-1 -: TAG_W];
  assign unused_ofs = ^{lk_ptr[LINE_OFS-1:0], fill_ptr[LINE_OFS-1:0]};

  assign hit      = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign hit_line = dat_q[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
      dat_q[fill_idx] <= fill_line;
    end
  end

endmodule

// File: rtl/segw_walk_ctrl.sv
// Traversal state machine: IDLE -> FETCH -> (WAIT) -> COMPARE -> ... -> DONE.
module segw_walk_ctrl
  import segw_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int PTR_W     = 32,
  parameter int IDX_W     = 11,
  parameter int LINE_W    = 512,
  parameter int MAX_DEPTH = 8,
  parameter int LINE_OFS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [KEY_W-1:0]  req_vaddr,
  output logic              req_ready,
  input  logic [PTR_W-1:0]  root_ptr,
  output logic [PTR_W-1:0]  cur_ptr,
  input  logic              cache_hit,
  input  logic [LINE_W-1:0] cache_line,
  output logic              fill_en,
  output logic [LINE_W-1:0] fill_line,
  output logic              mem_req_valid,
  output logic [PTR_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_line,
  output logic [LINE_W-1:0] node_line,
  output logic [KEY_W-1:0]  walk_vaddr,
  input  logic              sel_leaf,
  input  logic              sel_no_match,
  input  logic [PTR_W-1:0]  sel_slot,
  output logic              resp_valid,
  output logic [IDX_W-1:0]  resp_index,
  output logic [1:0]        resp_err
);
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);

  walk_state_t       state_q, state_d;
  logic [PTR_W-1:0]  ptr_q;
  logic [LINE_W-1:0] node_q;
  logic [KEY_W-1:0]  va_q;
  logic [DEPTH_W-1:0] depth_q;
  logic              kill_q;
  logic [IDX_W-1:0]  idx_q;
  walk_err_t         err_q, err_d;

  logic accept, load_hit, load_mem, at_cmp, depth_full, finish, descend;

  always_comb begin
    accept     = (state_q == ST_IDLE) && req_valid;
    load_hit   = (state_q == ST_FETCH) && cache_hit;
    load_mem   = (state_q == ST_WAIT) && mem_rsp_valid;
    at_cmp     = (state_q == ST_COMPARE);
    depth_full = (depth_q == DEPTH_W'(MAX_DEPTH));
    finish     = at_cmp && (sel_leaf || depth_full);
    descend    = at_cmp && !finish;
    if (!sel_leaf)         err_d = WERR_DEPTH;
    else if (sel_no_match) err_d = WERR_NOMATCH;
    else                   err_d = WERR_NONE;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_FETCH;
      ST_FETCH:   state_d = cache_hit ? ST_COMPARE : ST_WAIT;
      ST_WAIT:    if (mem_rsp_valid) state_d = ST_COMPARE;
      ST_COMPARE: state_d = finish ? ST_DONE : ST_FETCH;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      depth_q <= '0;
      kill_q  <= 1'b0;
      idx_q   <= '0;
      err_q   <= WERR_NONE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept)                  depth_q <= '0;
      else if (load_hit || load_mem) depth_q <= depth_q + DEPTH_W'(1);
      if (accept)                  kill_q <= 1'b0;
      else if (flush && state_q != ST_IDLE) kill_q <= 1'b1;
      if (accept)                  ptr_q <= root_ptr;
      else if (descend)            ptr_q <= sel_slot;
      if (finish) begin
        idx_q <= sel_slot[IDX_W-1:0];
        err_q <= err_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) va_q <= req_vaddr;
    if (load_hit)      node_q <= cache_line;
    else if (load_mem) node_q <= mem_rsp_line;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign cur_ptr       = ptr_q;
  assign mem_req_valid = (state_q == ST_FETCH) && !cache_hit;
  assign mem_req_addr  = {ptr_q[PTR_W-1:LINE_OFS], LINE_OFS'(0)};
  assign fill_en       = load_mem && !kill_q && !flush;
  assign fill_line     = mem_rsp_line;
  assign node_line     = node_q;
  assign walk_vaddr    = va_q;
  assign resp_valid    = (state_q == ST_DONE);
  assign resp_index    = idx_q;
  assign resp_err      = err_q;

endmodule

// File: rtl/segidx_walker.sv
module segidx_walker #(
  parameter int KEY_W      = 32,
  parameter int PTR_W      = 32,
  parameter int IDX_W      = 11,
  parameter int LINE_W     = 512,
  parameter int MAX_KEYS   = 7,
  parameter int MAX_DEPTH  = 8,
  parameter int NC_ENTRIES = 8,
  parameter int LINE_OFS   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              root_wr_en,
  input  logic [PTR_W-1:0]  root_wr_ptr,
  input  logic              req_valid,
  input  logic [KEY_W-1:0]  req_vaddr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [IDX_W-1:0]  resp_index,
  output logic [1:0]        resp_err,
  output logic              mem_req_valid,
  output logic [PTR_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_line
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [PTR_W-1:0]  root_q;
  logic [PTR_W-1:0]  cur_ptr;
  logic              cache_hit, fill_en;
  logic [LINE_W-1:0] cache_line, fill_line, node_line;
  logic [KEY_W-1:0]  walk_vaddr;
  logic              sel_leaf, sel_no_match;
  logic [PTR_W-1:0]  sel_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // R10: software-loaded root pointer
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)      root_q <= '0;
    else if (root_wr_en) root_q <= root_wr_ptr;
  end

  segw_walk_ctrl #(
    .KEY_W(KEY_W), .PTR_W(PTR_W), .IDX_W(IDX_W), .LINE_W(LINE_W),
    .MAX_DEPTH(MAX_DEPTH), .LINE_OFS(LINE_OFS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .flush(flush),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .root_ptr(root_q), .cur_ptr(cur_ptr),
    .cache_hit(cache_hit), .cache_line(cache_line),
    .fill_en(fill_en), .fill_line(fill_line),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
    .node_line(node_line), .walk_vaddr(walk_vaddr),
    .sel_leaf(sel_leaf), .sel_no_match(sel_no_match), .sel_slot(sel_slot),
    .resp_valid(resp_valid), .resp_index(resp_index), .resp_err(resp_err)
  );

  segw_node_cache #(
    .PTR_W(PTR_W), .LINE_W(LINE_W), .ENTRIES(NC_ENTRIES), .LINE_OFS(LINE_OFS)
  ) u_cache (
    .clk(clk), .rst_n(rst_n_int), .flush(flush),
    .lk_ptr(cur_ptr), .hit(cache_hit), .hit_line(cache_line),
    .fill_en(fill_en), .fill_ptr(cur_ptr), .fill_line(fill_line)
  );

  segw_key_select #(
    .KEY_W(KEY_W), .PTR_W(PTR_W), .MAX_KEYS(MAX_KEYS), .LINE_W(LINE_W)
  ) u_sel (
    .node_line(node_line), .vaddr(walk_vaddr),
    .is_leaf(sel_leaf), .no_match(sel_no_match), .sel_slot(sel_slot)
  );

endmodule

// File: rtl/segw_walker_chk.sv
module segw_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       resp_valid,
  input logic [1:0] resp_err,
  input logic       mem_req_valid
);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_ready_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> req_ready);

  a_r11_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r6_mem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  a_r6_no_mem_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  a_r4_err_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_err != 2'd3));
endmodule

bind segidx_walker segw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_err(resp_err), .mem_req_valid(mem_req_valid)
);

// File: tb/segidx_walker_test.sv
`timescale 1ns/1ps
module segidx_walker_test;
  logic         clk;
  logic         rst_n;
  logic         flush;
  logic         root_wr_en;
  logic [31:0]  root_wr_ptr;
  logic         req_valid;
  logic [31:0]  req_vaddr;
  logic         req_ready;
  logic         resp_valid;
  logic [10:0]  resp_index;
  logic [1:0]   resp_err;
  logic         mem_req_valid;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid;
  logic [511:0] mem_rsp_line;

  segidx_walker uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .root_wr_en(root_wr_en), .root_wr_ptr(root_wr_ptr),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_index(resp_index), .resp_err(resp_err),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int mem_reqs = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [10:0] idx;
    logic [1:0]  err;
    int          lat;
    string       tag;
  } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  logic [511:0] mem_lines [int unsigned];
  logic [31:0]  kb [7];
  logic [31:0]  vb [8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 7; i++) kb[i] = '0;
    for (int j = 0; j < 8; j++) vb[j] = '0;
  endtask

  // R2 layout: leaf bit 0, count 3:1, key i at 32+32i, slot j at 256+32j
  function automatic logic [511:0] mk(input bit leaf, input int cnt);
    logic [511:0] l;
    l = '0;
    l[0] = leaf;
    l[3:1] = cnt[2:0];
    for (int i = 0; i < 7; i++) l[32+32*i +: 32] = kb[i];
    for (int j = 0; j < 8; j++) l[256+32*j +: 32] = vb[j];
    return l;
  endfunction

  // memory model: 2 idle cycles then a one-cycle response
  initial begin
    logic [31:0] a;
    mem_rsp_valid = 1'b0;
    mem_rsp_line  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        mem_reqs++;
        a = mem_req_addr;
        chk(a[5:0] == 6'd0, "R12 read address line aligned", {26'd0, a[5:0]}, 32'd0);
        repeat (2) @(negedge clk);
        mem_rsp_line  = mem_lines.exists(a >> 6) ? mem_lines[a >> 6] : '0;
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 32'd1, 32'd0);
      end else begin
        mon_e = sbq.pop_front();
        chk(resp_err == mon_e.err, {mon_e.tag, " err"}, {30'd0, resp_err}, {30'd0, mon_e.err});
        if (mon_e.err == 2'd0)
          chk(resp_index == mon_e.idx, {mon_e.tag, " index"}, {21'd0, resp_index}, {21'd0, mon_e.idx});
        if (mon_e.lat >= 0)
          chk(cyc - acc_cyc == mon_e.lat, {mon_e.tag, " latency"}, cyc - acc_cyc, mon_e.lat);
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [10:0] eidx, input logic [1:0] eerr,
                      input int elat, input int emem, input string tag);
    exp_t e;
    int m0;
    e.idx = eidx; e.err = eerr; e.lat = elat; e.tag = tag;
    sbq.push_back(e);
    m0 = mem_reqs;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    acc_cyc = cyc;
    while (sbq.size() != 0) @(negedge clk);
    if (emem >= 0) chk(mem_reqs - m0 == emem, {tag, " memory reads"}, mem_reqs - m0, emem);
  endtask

  task automatic set_root(input logic [31:0] p);
    @(negedge clk);
    root_wr_en = 1'b1; root_wr_ptr = p;
    @(negedge clk);
    root_wr_en = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; root_wr_en = 1'b0; root_wr_ptr = '0;
    req_valid = 1'b0; req_vaddr = '0;

    // tree A: root 0x1000 internal, three leaves
    clr(); kb[0] = 32'h4000; kb[1] = 32'h8000;
    vb[0] = 32'h1040; vb[1] = 32'h1080; vb[2] = 32'h10C0;
    mem_lines[32'h1000 >> 6] = mk(1'b0, 2);
    clr(); kb[0] = 32'h1000; kb[1] = 32'h2000; vb[0] = 5; vb[1] = 6;
    mem_lines[32'h1040 >> 6] = mk(1'b1, 2);
    clr(); kb[0] = 32'h4000; kb[1] = 32'h6000; kb[2] = 32'h7000; vb[0] = 10; vb[1] = 11; vb[2] = 12;
    mem_lines[32'h1080 >> 6] = mk(1'b1, 3);
    clr(); kb[0] = 32'h8000; vb[0] = 20;
    mem_lines[32'h10C0 >> 6] = mk(1'b1, 1);
    // chain: nodes 0x2000..0x21C0 keyless internal, then leaf 0x2200
    for (int n = 0; n < 8; n++) begin
      clr(); vb[0] = 32'h2000 + 32'h40 * (n + 1);
      mem_lines[(32'h2000 + 32'h40 * n) >> 6] = mk(1'b0, 0);
    end
    clr(); kb[0] = 32'h0; vb[0] = 33;
    mem_lines[32'h2200 >> 6] = mk(1'b1, 1);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk(resp_valid == 1'b0, "R1 reset resp_valid", {31'd0, resp_valid}, 32'd0);
    chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

    set_root(32'h1000);
    walk(32'h1800, 11'd5, 2'd0, -1, 2, "R3 cold walk leaf value");
    walk(32'h1900, 11'd5, 2'd0, 4, 0, "R7 R11 cached two-level walk");
    walk(32'h0800, 11'd0, 2'd2, -1, 0, "R4 address below first leaf key");
    walk(32'h4000, 11'd10, 2'd0, -1, 1, "R2 key equal selects child");
    walk(32'h3FFF, 11'd6, 2'd0, -1, 0, "R2 just below separator");
    walk(32'h7FFF, 11'd12, 2'd0, -1, 0, "R3 last key of leaf");
    walk(32'hFFFF_FFFF, 11'd20, 2'd0, -1, 1, "R2 top child");
    walk(32'h6000, 11'd11, 2'd0, -1, 0, "R6 all nodes cached");

    pulse_flush();
    walk(32'h1800, 11'd5, 2'd0, -1, 2, "R8 refetch after flush");

    pulse_flush();
    fork
      walk(32'h6000, 11'd11, 2'd0, -1, 2, "R9 walk with flush in flight");
      begin
        @(negedge clk);
        while (!mem_req_valid) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
    join
    walk(32'h6000, 11'd11, 2'd0, -1, 2, "R9 nothing installed after flush");
    walk(32'h6000, 11'd11, 2'd0, -1, 0, "R7 installed on clean walk");

    fork
      walk(32'h1800, 11'd5, 2'd0, -1, 1, "R10 root write during walk");
      begin
        @(negedge clk);
        while (!mem_req_valid) @(negedge clk);
        root_wr_en = 1'b1; root_wr_ptr = 32'h2000;
        @(negedge clk);
        root_wr_en = 1'b0;
      end
    join
    walk(32'h5555, 11'd0, 2'd1, -1, 8, "R5 R10 depth cap on new root");

    set_root(32'h2040);
    walk(32'h1234, 11'd33, 2'd0, -1, 1, "R5 leaf at eighth level");

    set_root(32'h103F);
    walk(32'h4000, 11'd10, 2'd0, -1, 2, "R12 pointer offset bits ignored");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule